// File: doc/BRIEF.md
# Vector Segment Broadcast Chain

This block loads one segment of a dense vector into private on-chip copies held by a row of processing engines. The vector arrives as wide words on a ready/valid stream. Each word packs several single-precision values side by side. A pulse on the segment-start input opens a load. The block then accepts exactly one segment's worth of words and writes each one into engine 0.

Each engine passes every word it receives to the next engine through one register per hop. Words therefore reach the engines one after another instead of over a wide fan-out. Each engine raises its own done flag once the final word of the segment has been written into its copy.

Every engine owns a read port for random column lookups. Because every copy is complete and private, reads from different engines never contend. The segment length, lane count, lane width and engine count are all parameters. The default segment length is kept modest. The intended full-size setting of 8192 entries needs only a parameter change.

Top module: `vec_seg_chain`

## Requirements
- R1: After reset, `seg_done_o` is all zeros and `in_ready_o` is low.
- R2: A `seg_start_i` pulse sampled while the block is idle clears every `seg_done_o` bit and raises `in_ready_o` on the next cycle.
- R3: Lane j of the k-th word of a segment is bits [32j+31:32j] of `in_data_i`. It is stored at entry address k*16+j, so addresses run from 0 to SEG_LEN-1. The entry is readable from every engine.
- R4: An engine's `rd_data_o` slice shows the entry selected by its `rd_addr_i` slice at the previous rising edge, one cycle of latency.
- R5: `in_ready_o` stays high until SEG_LEN/16 words have been accepted. It is low in the cycle after the last of them.
- R6: Engine 0's done bit rises at the edge that accepts the last word. Engine i's done bit rises exactly i cycles later.
- R7: When `in_valid_i` has gaps, the whole chain holds. The stored data and the done timing relative to the last accepted word do not change.
- R8: `seg_start_i` is ignored while a segment is loading or draining through the chain.
- R9: Words presented while `in_ready_o` is low are not written to any engine.
- R10: A new segment overwrites every entry of every engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seg_start_i | input | 1 | Opens a new segment load when idle |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Block accepts a word this cycle |
| in_data_i | input | 512 | Sixteen packed 32-bit vector values |
| seg_done_o | output | 8 | Per-engine segment copy complete |
| rd_addr_i | input | 88 | Per-engine entry address, 11 bits each, engine e at [11e+10:11e] |
| rd_data_o | output | 256 | Per-engine read data, 32 bits each, engine e at [32e+31:32e] |

## Verification
The assertions check the following on every cycle:
- the done bits rise in engine order and only from a final-word write;
- hop registers hold still whenever the chain does not step;
- a start pulse during draining never restarts a load;
- the idle-start transition clears state;
- ready stays low once the last engine is done.

Only the bench's scenarios can show that:
- data lands at the right entry addresses in every copy;
- the exact cycle offsets of the done bits are correct;
- words offered outside a load leave the copies untouched;
- a later segment replaces all earlier contents.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DRAIN = 2'd2
  } vsc_state_e;
endpackage

// File: rtl/vsc_ctrl.sv
module vsc_ctrl
  import vsc_pkg::*;
#(
  parameter int WORDS = 128,
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seg_start_i,
  input  logic             in_valid_i,
  input  logic             last_arrive_i,
  output logic             in_ready_o,
  output logic             accept_o,
  output logic             step_o,
  output logic             start_o,
  output logic [IDX_W-1:0] cnt_o
);
  vsc_state_e       state_q, state_d;
  logic [IDX_W-1:0] cnt_q;
  logic             accept_last;

  assign start_o     = (state_q == ST_IDLE) && seg_start_i;
  assign accept_o    = (state_q == ST_LOAD) && in_valid_i;
  assign accept_last = accept_o && (cnt_q == IDX_W'(WORDS - 1));
  assign step_o      = accept_o || (state_q == ST_DRAIN);
  assign in_ready_o  = (state_q == ST_LOAD);
  assign cnt_o       = cnt_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (seg_start_i) state_d = ST_LOAD;
      ST_LOAD:  if (last_arrive_i) state_d = ST_IDLE;
                else if (accept_last) state_d = ST_DRAIN;
      ST_DRAIN: if (last_arrive_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_o)       cnt_q <= '0;
      else if (accept_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r2_start_opens_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && seg_start_i) |=> (in_ready_o && cnt_q == '0));
  a_r8_no_restart_in_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && seg_start_i) |=> (state_q != ST_LOAD));
  a_r5_ready_drops_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_last |=> !in_ready_o);
endmodule

// File: rtl/vsc_hop.sv
module vsc_hop #(
  parameter int IDX_W  = 7,
  parameter int WORD_W = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              v_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] dat_i,
  output logic              v_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WORD_W-1:0] dat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= 1'b0;
      idx_o <= '0;
      dat_o <= '0;
    end else if (step_i) begin
      v_o   <= v_i;
      idx_o <= idx_i;
      dat_o <= dat_i;
    end
  end

  // whole chain freezes with the stream
  a_r7_hop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(v_o) && $stable(idx_o) && $stable(dat_o)));
endmodule

// File: rtl/vsc_engine.sv
module vsc_engine #(
  parameter int LANES  = 16,
  parameter int LANE_W = 32,
  parameter int WORDS  = 128,
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 11
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              seg_clr_i,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [LANES-1:0][LANE_W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [LANE_W-1:0]                 rd_data_o,
  output logic                              done_o
);
  localparam int LANE_IDX_W = $clog2(LANES);

  logic [LANES-1:0][LANE_W-1:0] mem [WORDS];
  logic [IDX_W-1:0]      rd_row;
  logic [LANE_IDX_W-1:0] rd_lane;
  logic                  wr_last;

  assign rd_row  = rd_addr_i[ADDR_W-1:LANE_IDX_W];
  assign rd_lane = rd_addr_i[LANE_IDX_W-1:0];
  assign wr_last = wr_en_i && (wr_idx_i == IDX_W'(WORDS - 1));

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_idx_i] <= wr_data_i;
    rd_data_o <= mem[rd_row][rd_lane];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        done_o <= 1'b0;
    else if (seg_clr_i) done_o <= 1'b0;
    else if (wr_last)   done_o <= 1'b1;
  end

  a_r6_done_from_last_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_en_i && wr_idx_i == IDX_W'(WORDS - 1)));
endmodule

// File: rtl/vec_seg_chain.sv
module vec_seg_chain #(
  parameter int LANES   = 16,
  parameter int LANE_W  = 32,
  parameter int SEG_LEN = 2048,
  parameter int N_ENG   = 8,
  localparam int WORD_W = LANES * LANE_W,
  localparam int ADDR_W = $clog2(SEG_LEN)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      seg_start_i,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [WORD_W-1:0]         in_data_i,
  output logic [N_ENG-1:0]          seg_done_o,
  input  logic [N_ENG*ADDR_W-1:0]   rd_addr_i,
  output logic [N_ENG*LANE_W-1:0]   rd_data_o
);
  localparam int WORDS = SEG_LEN / LANES;
  localparam int IDX_W = $clog2(WORDS);

  logic             accept, step, start, last_arrive;
  logic [IDX_W-1:0] cnt;

  logic              inc_v   [N_ENG];
  logic [IDX_W-1:0]  inc_idx [N_ENG];
  logic [WORD_W-1:0] inc_dat [N_ENG];

  assign last_arrive = step && inc_v[N_ENG-1] && (inc_idx[N_ENG-1] == IDX_W'(WORDS - 1));

  vsc_ctrl #(.WORDS(WORDS), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .seg_start_i, .in_valid_i,
    .last_arrive_i(last_arrive), .in_ready_o,
    .accept_o(accept), .step_o(step), .start_o(start), .cnt_o(cnt)
  );

  for (genvar i = 0; i < N_ENG; i++) begin : g_eng
    if (i == 0) begin : g_head
      assign inc_v[i]   = accept;
      assign inc_idx[i] = cnt;
      assign inc_dat[i] = in_data_i;
    end else begin : g_hop
      vsc_hop #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_hop (
        .clk_i, .rst_ni, .step_i(step),
        .v_i(inc_v[i-1]), .idx_i(inc_idx[i-1]), .dat_i(inc_dat[i-1]),
        .v_o(inc_v[i]),   .idx_o(inc_idx[i]),   .dat_o(inc_dat[i])
      );
    end

    vsc_engine #(
      .LANES(LANES), .LANE_W(LANE_W), .WORDS(WORDS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_eng (
      .clk_i, .rst_ni,
      .seg_clr_i(start),
      .wr_en_i(step && inc_v[i]),
      .wr_idx_i(inc_idx[i]),
      .wr_data_i(inc_dat[i]),
      .rd_addr_i(rd_addr_i[i*ADDR_W +: ADDR_W]),
      .rd_data_o(rd_data_o[i*LANE_W +: LANE_W]),
      .done_o(seg_done_o[i])
    );

    if (i > 0) begin : g_ord
      a_r6_done_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(seg_done_o[i]) |-> seg_done_o[i-1]);
    end
  end

  a_r5_no_ready_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_done_o[N_ENG-1] |-> !in_ready_o);
endmodule

// File: tb/vec_seg_chain_bench.sv
module vec_seg_chain_bench;
  localparam int LANES = 16, LANE_W = 32, SEG_LEN = 2048, N_ENG = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int ADDR_W = $clog2(SEG_LEN);
  localparam int WORDS  = SEG_LEN / LANES;

  logic clk = 1'b0, rst_n = 1'b0;
  logic seg_start = 1'b0, in_valid = 1'b0, in_ready;
  logic [WORD_W-1:0] in_data = '0;
  logic [N_ENG-1:0] done, prev_done = '0;
  logic [N_ENG*ADDR_W-1:0] rd_addr = '0;
  logic [N_ENG*LANE_W-1:0] rd_data;

  int total = 0, bad = 0, cyc = 0;
  int exp_eng[$], exp_cyc[$];
  string exp_tag[$];
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vec_seg_chain #(.LANES(LANES), .LANE_W(LANE_W), .SEG_LEN(SEG_LEN), .N_ENG(N_ENG))
  u_vec_seg_chain (
    .clk_i(clk), .rst_ni(rst_n), .seg_start_i(seg_start), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .in_data_i(in_data), .seg_done_o(done),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic logic [31:0] val(int seg, int addr);
    return (32'(seg) << 24) ^ (32'(addr) * 32'h0001_0001) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [WORD_W-1:0] mk_word(int seg, int k);
    logic [WORD_W-1:0] w;
    for (int j = 0; j < LANES; j++) w[j*LANE_W +: LANE_W] = val(seg, k*LANES + j);
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] junk_word(int n);
    logic [WORD_W-1:0] w;
    for (int j = 0; j < LANES; j++) w[j*LANE_W +: LANE_W] = 32'hFFFF_0000 | 32'(n*LANES + j);
    return w;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // monitor: pops expected done events as each engine's bit rises
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N_ENG; i++) begin
        if (done[i] && !prev_done[i]) begin
          total++;
          if (exp_eng.size() == 0) begin
            bad++;
            $display("FAIL R6 unexpected done eng=%0d got cyc=%0d exp none", i, cyc);
          end else begin
            int e, c;
            string t;
            e = exp_eng.pop_front();
            c = exp_cyc.pop_front();
            t = exp_tag.pop_front();
            if (e != i || c != cyc) begin
              bad++;
              $display("FAIL R6 %s done got eng=%0d cyc=%0d exp eng=%0d cyc=%0d", t, i, cyc, e, c);
            end
          end
        end
      end
      prev_done = done;
    end
  end

  // mode 0: no gaps; mode 1: gaps and start pulses while busy; mode 2: alternate gaps
  task automatic run_seg(int seg, int mode, string tag);
    int last;
    @(negedge clk);
    seg_start = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    seg_start = 1'b0;
    check("R2 ready after start", 64'(in_ready), 64'd1);
    check("R2 done cleared", 64'(done), 64'd0);
    for (int k = 0; k < WORDS; k++) begin
      if ((mode == 1 && k % 3 == 1) || (mode == 2 && k % 2 == 0)) begin
        in_valid = 1'b0;
        in_data  = junk_word(k);
        @(negedge clk);
        if (k == 7) check("R7 ready held in gap", 64'(in_ready), 64'd1);
      end
      in_valid = 1'b1;
      in_data  = mk_word(seg, k);
      if (mode == 1 && k == 5) seg_start = 1'b1;   // R8: pulse mid-load
      if (k == WORDS - 2) check("R5 ready before last", 64'(in_ready), 64'd1);
      @(posedge clk);
      #1;
      seg_start = 1'b0;
      if (k == WORDS - 1) begin
        last = cyc;
        for (int i = 0; i < N_ENG; i++) begin
          exp_eng.push_back(i);
          exp_cyc.push_back(last + i);
          exp_tag.push_back(tag);
        end
      end
      @(negedge clk);
    end
    check("R5 ready low after last", 64'(in_ready), 64'd0);
    // R9: words offered while not ready must be dropped
    for (int n = 0; n < N_ENG + 3; n++) begin
      in_valid = 1'b1;
      in_data  = junk_word(n + 100);
      if (mode == 1 && n == 1) seg_start = 1'b1;   // R8: pulse while draining
      @(negedge clk);
      seg_start = 1'b0;
    end
    in_valid = 1'b0;
    check("R6 all engines done", 64'(done), 64'((1 << N_ENG) - 1));
    check("R8 still idle not loading", 64'(in_ready), 64'd0);
  endtask

  task automatic read_pass(int seg, string tag);
    for (int j = 0; j < 20; j++) begin
      int base;
      case (j)
        0: base = 0;
        1: base = LANES - 1;
        2: base = LANES;
        3: base = SEG_LEN - 1;
        default: base = (j * 389) % SEG_LEN;
      endcase
      @(negedge clk);
      for (int e = 0; e < N_ENG; e++)
        rd_addr[e*ADDR_W +: ADDR_W] = ADDR_W'((base + e*(LANES + 1)) % SEG_LEN);
      @(negedge clk);
      for (int e = 0; e < N_ENG; e++) begin
        int a;
        a = (base + e*(LANES + 1)) % SEG_LEN;
        total++;
        if (rd_data[e*LANE_W +: LANE_W] !== val(seg, a)) begin
          bad++;
          $display("FAIL R3 R4 %s eng=%0d addr=%0d got=%h exp=%h", tag, e, a,
                   rd_data[e*LANE_W +: LANE_W], val(seg, a));
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done after reset", 64'(done), 64'd0);
    check("R1 ready after reset", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready idle", 64'(in_ready), 64'd0);

    run_seg(1, 0, "R6");
    read_pass(1, "R9");
    run_seg(2, 1, "R8");
    read_pass(2, "R7");
    run_seg(3, 2, "R6");
    read_pass(3, "R10");

    total++;
    if (exp_eng.size() != 0) begin
      bad++;
      $display("FAIL R6 missing done events got=%0d exp=0", exp_eng.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule